// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the host-side read and write strobes for programmed-I/O transfers on two IDE channels carrying up to four drives. Each transfer runs three phases: address setup, an active phase with the selected strobe asserted, and a recovery phase. The length of each phase comes from a per-drive configuration held in the block.

Drives 0 and 1 each own an address-timing byte and a data-timing byte. Drives 2 and 3 share one pair of bytes. The counts are stored in an encoded form, and a silicon revision input lengthens recovery by one clock on later parts. A small register write port loads the bytes. Each drive's prefetch-disable bit is stored and driven out continuously.

A request is accepted only while the block is idle. Its timing is captured at that moment, so a register write made during a transfer applies from the next transfer onward.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset the block is idle (busy, done and both strobes low), every stored byte is 0x00, `pf_dis` is 0, and every drive runs setup 4, active 16, recovery 16 clocks.
- R2: Bits 7:6 of an address-timing byte choose the setup length: 2'b00 is 4 clocks, 2'b01 is 2, 2'b10 is 3 and 2'b11 is 5.
- R3: In a data-timing byte, bits 7:4 give the active count and bits 3:0 give the recovery count. A nibble of 0 stands for 16 clocks.
- R4: An active count of 1 runs as 2 clocks.
- R5: When the effective active count is above 3 and the recovery nibble is 1, recovery runs 2 clocks. With an active count of 3 or less, a recovery of 1 stays at 1.
- R6: When `rev` is greater than 1, recovery lasts one clock longer than the value that R3 and R5 give.
- R7: The write addresses are: 0 for address timing of drive 0, 1 for data timing of drive 0, 2 and 3 for the same bytes of drive 1, 4 and 5 for the shared bytes of drives 2 and 3, and 6 for the control byte. Drives 2 and 3 both use addresses 4 and 5.
- R8: Addresses 8, 9 and 10 write only bits 7:6 of the address-timing byte for drive 0, drive 1 and the shared drives 2/3, and leave bits 5:0 unchanged. Addresses 7 and 11 to 15 are ignored.
- R9: `pf_dis[0]` and `pf_dis[1]` show bits 6 and 7 of the control byte. `pf_dis[2]` and `pf_dis[3]` show bits 2 and 3 of the shared address-timing byte.
- R10: A request is accepted only while `busy` is low. `busy` goes high on the clock after acceptance and stays high for setup+active+recovery cycles. `done` is high for exactly one cycle, the last recovery cycle. A request held high while busy starts nothing until the block is idle again.
- R11: A register write during a transfer does not change that transfer's timing. It applies to the next accepted request.
- R12: During the active phase only, `strobe_wr` is high if `req_write` was 1 at acceptance, otherwise `strobe_rd` is high. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| rev | input | 2 | Silicon revision code |
| req | input | 1 | Start a transfer |
| req_drive | input | 2 | Drive index of the request |
| req_write | input | 1 | 1 for a write transfer, 0 for a read |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Last recovery cycle |
| strobe_rd | output | 1 | Read strobe, active high |
| strobe_wr | output | 1 | Write strobe, active high |
| pf_dis | output | 4 | Prefetch-disable bit for each drive |

## Verification
A wrong phase count or a wrong decode shows at the ports inside the same transfer. The strobe rises or falls one or more cycles off, or `done` moves, and the cycle-by-cycle comparison catches it at the first cycle that differs. A wrong register selection or a lost write shows as a wrong phase length on the next transfer to the affected drive. It can also show at once on `pf_dis` when the damaged byte holds a prefetch bit. For that reason the setup-only write is checked through the shared byte, whose low bits drive `pf_dis[3:2]`.

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [1:0]    rev,
  input  logic          req,
  input  logic [1:0]    req_drive,
  input  logic          req_write,
  output logic          busy,
  output logic          done,
  output logic          strobe_rd,
  output logic          strobe_wr,
  output logic [3:0]    pf_dis
);
  typedef enum logic [1:0] {IDLE, SETUP, ACT, REC} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt, act_q, rec_q;
  logic          wr_q;
  logic [DW-1:0] at0, dt0, at1, dt1, at23, dt23, ctrl;
  logic [DW-1:0] at_sel, dt_sel;
  logic [CW-1:0] setup_len, act_raw, act_len, rec_raw, rec_adj, rec_len;
  logic          accept;

  assign at_sel = req_drive[1] ? at23 : (req_drive[0] ? at1 : at0);
  assign dt_sel = req_drive[1] ? dt23 : (req_drive[0] ? dt1 : dt0);

  always_comb begin
    case (at_sel[7:6])
      2'b00:   setup_len = CW'(4);
      2'b01:   setup_len = CW'(2);
      2'b10:   setup_len = CW'(3);
      default: setup_len = CW'(5);
    endcase
  end

  assign act_raw = (dt_sel[7:4] == 4'd0) ? CW'(16) : CW'(dt_sel[7:4]);
  assign act_len = (act_raw == CW'(1)) ? CW'(2) : act_raw;
  assign rec_raw = (dt_sel[3:0] == 4'd0) ? CW'(16) : CW'(dt_sel[3:0]);
  assign rec_adj = (act_len > CW'(3) && rec_raw == CW'(1)) ? CW'(2) : rec_raw;
  assign rec_len = rec_adj + ((rev > 2'd1) ? CW'(1) : CW'(0));

  assign accept    = (phase == IDLE) && req;
  assign busy      = (phase != IDLE);
  assign done      = (phase == REC) && (cnt == '0);
  assign strobe_rd = (phase == ACT) && !wr_q;
  assign strobe_wr = (phase == ACT) && wr_q;
  assign pf_dis    = {at23[3], at23[2], ctrl[7], ctrl[6]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= IDLE;
      cnt   <= '0;
      act_q <= '0;
      rec_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      case (phase)
        IDLE: if (accept) begin
          phase <= SETUP;
          cnt   <= setup_len - CW'(1);
          act_q <= act_len;
          rec_q <= rec_len;
          wr_q  <= req_write;
        end
        SETUP: if (cnt == '0) begin
          phase <= ACT;
          cnt   <= act_q - CW'(1);
        end else cnt <= cnt - CW'(1);
        ACT: if (cnt == '0) begin
          phase <= REC;
          cnt   <= rec_q - CW'(1);
        end else cnt <= cnt - CW'(1);
        default: if (cnt == '0) phase <= IDLE;
                 else cnt <= cnt - CW'(1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      at0 <= '0; dt0 <= '0; at1 <= '0; dt1 <= '0;
      at23 <= '0; dt23 <= '0; ctrl <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0):  at0  <= cfg_wdata;
        AW'(1):  dt0  <= cfg_wdata;
        AW'(2):  at1  <= cfg_wdata;
        AW'(3):  dt1  <= cfg_wdata;
        AW'(4):  at23 <= cfg_wdata;
        AW'(5):  dt23 <= cfg_wdata;
        AW'(6):  ctrl <= cfg_wdata;
        AW'(8):  at0[7:6]  <= cfg_wdata[7:6];
        AW'(9):  at1[7:6]  <= cfg_wdata[7:6];
        AW'(10): at23[7:6] <= cfg_wdata[7:6];
        default: ;
      endcase
    end
  end

  // R10: done lasts a single cycle and is followed by idle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r10_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);
  // R12: strobes exclusive and confined to a transfer
  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_rd && strobe_wr));
  a_r12_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rd || strobe_wr) |-> busy);
  // R12: direction held steady for the whole active phase
  a_r12_strobe_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rd && $past(strobe_wr)) |-> 1'b0);
endmodule

// File: tb/ide_pio_timer_tb_top.sv
module ide_pio_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] rev = '0;
  logic req = 1'b0;
  logic [1:0] req_drive = '0;
  logic req_write = 1'b0;
  logic busy, done, strobe_rd, strobe_wr;
  logic [3:0] pf_dis;

  always #10 clk = ~clk;

  ide_pio_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rev(rev), .req(req), .req_drive(req_drive),
    .req_write(req_write), .busy(busy), .done(done), .strobe_rd(strobe_rd),
    .strobe_wr(strobe_wr), .pf_dis(pf_dis)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit started = 0;

  // behavioural reference: byte array, elapsed-cycle counter, phase lengths
  int m_at[3] = '{0, 0, 0};
  int m_dt[3] = '{0, 0, 0};
  int m_ctrl = 0;
  bit m_busy = 0;
  int t = 0, sl = 0, al = 0, rl = 0;
  bit m_wr = 0;

  function automatic int setup_of(int code);
    case (code)
      0: return 4;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_at = '{0, 0, 0}; m_dt = '{0, 0, 0}; m_ctrl = 0; m_busy = 0; t = 0;
    end else begin
      if (m_busy) begin
        t++;
        if (t == sl + al + rl) m_busy = 0;
      end else if (req) begin
        int idx;
        idx = (req_drive >= 2) ? 2 : int'(req_drive);
        sl = setup_of((m_at[idx] >> 6) & 3);
        al = (m_dt[idx] >> 4) & 15;
        if (al == 0) al = 16;
        if (al == 1) al = 2;
        rl = m_dt[idx] & 15;
        if (rl == 0) rl = 16;
        if (al > 3 && rl == 1) rl = 2;
        if (rev > 1) rl++;
        t = 0; m_busy = 1; m_wr = req_write;
      end
      if (cfg_we) begin
        case (cfg_addr)
          0: m_at[0] = cfg_wdata;
          1: m_dt[0] = cfg_wdata;
          2: m_at[1] = cfg_wdata;
          3: m_dt[1] = cfg_wdata;
          4: m_at[2] = cfg_wdata;
          5: m_dt[2] = cfg_wdata;
          6: m_ctrl = cfg_wdata;
          8: m_at[0] = (m_at[0] & 8'h3F) | (cfg_wdata & 8'hC0);
          9: m_at[1] = (m_at[1] & 8'h3F) | (cfg_wdata & 8'hC0);
          10: m_at[2] = (m_at[2] & 8'h3F) | (cfg_wdata & 8'hC0);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    bit e_act, e_done;
    int e_pf;
    e_act  = m_busy && t >= sl && t < sl + al;
    e_done = m_busy && t == sl + al + rl - 1;
    e_pf   = (((m_at[2] >> 3) & 1) << 3) | (((m_at[2] >> 2) & 1) << 2)
           | (((m_ctrl >> 7) & 1) << 1) | ((m_ctrl >> 6) & 1);
    chk("busy", busy, m_busy);
    chk("done", done, e_done);
    chk("strobe_rd", strobe_rd, e_act && !m_wr);
    chk("strobe_wr", strobe_wr, e_act && m_wr);
    chk("pf_dis", pf_dis, e_pf);
  end

  task automatic wreg(int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xfer(int drv, bit wr);
    @(negedge clk);
    req = 1; req_drive = 2'(drv); req_write = wr;
    @(negedge clk);
    req = 0;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: default slowest timing 4/16/16
    tag = "R1"; xfer(0, 0); xfer(3, 1);
    // R2: setup codes
    tag = "R2";
    wreg(0, 8'h40); xfer(0, 0);
    wreg(0, 8'h80); xfer(0, 1);
    wreg(0, 8'hC0); xfer(0, 0);
    // R3: nibble placement and zero means sixteen
    tag = "R3"; wreg(1, 8'h25); xfer(0, 0);
    wreg(1, 8'h70); xfer(0, 1);
    // R4: active of one runs as two
    tag = "R4"; wreg(1, 8'h13); xfer(0, 0);
    // R5: recovery stretch only above active three
    tag = "R5"; wreg(1, 8'h41); xfer(0, 0);
    wreg(1, 8'h31); xfer(0, 1);
    // R6: later revision adds one recovery clock
    tag = "R6"; rev = 2; xfer(0, 0); rev = 1; xfer(0, 0);
    // R7: drive 1 separate, drives 2 and 3 shared
    tag = "R7"; wreg(2, 8'h80); wreg(3, 8'h32); xfer(1, 0); xfer(0, 0);
    wreg(4, 8'hC0); wreg(5, 8'h23); xfer(2, 1); xfer(3, 0);
    // R9: prefetch-disable bits
    tag = "R9"; wreg(6, 8'hC0); wreg(6, 8'h40); wreg(4, 8'h0C);
    // R8: setup-only write keeps low bits; unused address ignored
    tag = "R8"; wreg(10, 8'h7F); xfer(2, 0);
    wreg(8, 8'h80); xfer(0, 0);
    wreg(7, 8'hFF); wreg(12, 8'hFF); xfer(1, 0);
    // R10: request held across a transfer
    tag = "R10";
    @(negedge clk); req = 1; req_drive = 0; req_write = 1;
    repeat (40) @(negedge clk);
    req = 0;
    while (m_busy) @(negedge clk);
    // R11: write during a transfer applies to the next one
    tag = "R11";
    @(negedge clk); req = 1; req_drive = 1; req_write = 0;
    @(negedge clk); req = 0;
    wreg(3, 8'h22); wreg(2, 8'h40);
    while (m_busy) @(negedge clk);
    xfer(1, 0);
    // R12: direction selection
    tag = "R12"; xfer(2, 1); xfer(2, 0);
    // R1: reset restores defaults
    tag = "R1"; @(negedge clk); rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    xfer(1, 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule